// File: doc/BRIEF.md
# Mesh Router Route Computation Unit

This block decides where the head flit of a packet leaves a two-dimensional mesh router. For each head-flit request it returns an output port and, in table mode, the virtual channel that the packet must use at the next router. Body and tail flits never come here. The flit buffer logic keeps the port returned for the head and reuses it for the rest of the packet.

A build parameter picks one of three routing schemes. XY dimension order moves the packet along X until the column matches, and then along Y. YX dimension order moves along Y first. Table routing looks up the packet's flow identifier in a small programmable table. Each table entry holds an output port and a next-hop virtual channel, so a table can encode minimal or non-minimal paths and static channel assignment. The table is loaded through a write port before traffic starts.

A request is a single-cycle pulse carrying the destination coordinates, the flow identifier and the coordinates of this node. The result is registered and appears on the cycle after the request.

Top module: `route_compute_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, `res_valid` is 0, `res_port` is 0 (local) and `res_vc` is 0.
- R2: `res_valid` is high in exactly the cycles that follow a cycle with `req_valid` high. The result belongs to that request.
- R3: In a cycle after one with `req_valid` low, `res_port` and `res_vc` keep their previous values.
- R4: Output port codes are local=0, east=1, west=2, north=3, south=4, and `res_port` never takes another value. In both dimension-order modes, a destination equal to the local node gives local (0).
- R5: XY mode (ALG=0): if the destination X is greater than the local X the port is east, and if it is smaller the port is west. Only when the X values are equal does Y decide: a greater destination Y gives north and a smaller one gives south.
- R6: YX mode (ALG=1): Y is compared first (north if the destination Y is greater, south if it is smaller). X decides east or west only when the Y values are equal.
- R7: In both dimension-order modes `res_vc` is 0. The flow identifier and the table write port have no effect on the result.
- R8: Table mode (ALG=2): `res_port` and `res_vc` are the fields of the entry addressed by `flow_id`. The destination and local coordinates have no effect on the result.
- R9: A table write takes effect for requests made in later cycles. A request made in the same cycle as a write to its entry gets the old contents.
- R10: A table write with a port code above 4 (5, 6 or 7) stores local (0).
- R11: Reset sets every table entry to local port 0 and virtual channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Head-flit route request, one cycle per request |
| dest_x | input | COORD_W | Destination column |
| dest_y | input | COORD_W | Destination row |
| flow_id | input | FLOW_W | Flow identifier of the packet |
| local_x | input | COORD_W | Column of this router |
| local_y | input | COORD_W | Row of this router |
| tbl_wr_en | input | 1 | Routing table write strobe |
| tbl_wr_addr | input | FLOW_W | Entry to write |
| tbl_wr_port | input | 3 | Output port code to store |
| tbl_wr_vc | input | VC_W | Next-hop virtual channel to store |
| res_valid | output | 1 | Route result valid |
| res_port | output | 3 | Output port code |
| res_vc | output | VC_W | Next-hop virtual channel |

## Verification
The properties assume that coordinates are plain unsigned values and that each request is judged against the inputs present in its own request cycle. They make no assumption about where `local_x` and `local_y` sit in the mesh, and requests may arrive back to back. The stimulus draws coordinates, flow identifiers and table writes at random over their full widths, with request gaps and same-cycle write and lookup collisions mixed in. It then adds directed cases where the destination equals the local node or shares one coordinate with it. Table write codes include the illegal values 5 to 7, so the stored substitute is exercised.

// File: rtl/route_compute_pkg.sv
package route_compute_pkg;

    localparam int ALG_XY    = 0;
    localparam int ALG_YX    = 1;
    localparam int ALG_TABLE = 2;

    typedef enum logic [2:0] {
        PORT_LOCAL = 3'd0,
        PORT_EAST  = 3'd1,
        PORT_WEST  = 3'd2,
        PORT_NORTH = 3'd3,
        PORT_SOUTH = 3'd4
    } port_e;

    // Map any raw 3-bit code onto a legal port; unknown codes become local.
    function automatic port_e legal_port(input logic [2:0] code);
        port_e p;
        case (code)
            3'd1:    p = PORT_EAST;
            3'd2:    p = PORT_WEST;
            3'd3:    p = PORT_NORTH;
            3'd4:    p = PORT_SOUTH;
            default: p = PORT_LOCAL;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rcu_dor.sv
module rcu_dor
    import route_compute_pkg::*;
#(
    parameter int COORD_W = 3,
    parameter bit Y_FIRST = 1'b0
) (
    input  logic [COORD_W-1:0] dest_x,
    input  logic [COORD_W-1:0] dest_y,
    input  logic [COORD_W-1:0] here_x,
    input  logic [COORD_W-1:0] here_y,
    output port_e              port
);

    port_e x_step;
    port_e y_step;
    logic  x_match;
    logic  y_match;

    always_comb begin
        x_match = (dest_x == here_x);
        y_match = (dest_y == here_y);
        x_step  = (dest_x > here_x) ? PORT_EAST  : PORT_WEST;
        y_step  = (dest_y > here_y) ? PORT_NORTH : PORT_SOUTH;
    end

    generate
        if (Y_FIRST) begin : g_yx
            always_comb begin
                if (!y_match)      port = y_step;
                else if (!x_match) port = x_step;
                else               port = PORT_LOCAL;
            end
        end else begin : g_xy
            always_comb begin
                if (!x_match)      port = x_step;
                else if (!y_match) port = y_step;
                else               port = PORT_LOCAL;
            end
        end
    endgenerate

endmodule

// File: rtl/rcu_table.sv
module rcu_table
    import route_compute_pkg::*;
#(
    parameter int FLOW_W = 4,
    parameter int VC_W   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [FLOW_W-1:0] wr_addr,
    input  logic [2:0]        wr_port,
    input  logic [VC_W-1:0]   wr_vc,
    input  logic [FLOW_W-1:0] rd_addr,
    output port_e             rd_port,
    output logic [VC_W-1:0]   rd_vc
);

    localparam int DEPTH = 1 << FLOW_W;

    port_e           port_q [DEPTH];
    logic [VC_W-1:0] vc_q   [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                port_q[i] <= PORT_LOCAL;
                vc_q[i]   <= '0;
            end
        end else if (wr_en) begin
            port_q[wr_addr] <= legal_port(wr_port);
            vc_q[wr_addr]   <= wr_vc;
        end
    end

    assign rd_port = port_q[rd_addr];
    assign rd_vc   = vc_q[rd_addr];

endmodule

// File: rtl/route_compute_unit.sv
module route_compute_unit
    import route_compute_pkg::*;
#(
    parameter int COORD_W = 3,
    parameter int FLOW_W  = 4,
    parameter int NUM_VC  = 2,
    parameter int ALG     = ALG_XY,
    localparam int VC_W   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [COORD_W-1:0] dest_x,
    input  logic [COORD_W-1:0] dest_y,
    input  logic [FLOW_W-1:0]  flow_id,
    input  logic [COORD_W-1:0] local_x,
    input  logic [COORD_W-1:0] local_y,
    input  logic               tbl_wr_en,
    input  logic [FLOW_W-1:0]  tbl_wr_addr,
    input  logic [2:0]         tbl_wr_port,
    input  logic [VC_W-1:0]    tbl_wr_vc,
    output logic               res_valid,
    output logic [2:0]         res_port,
    output logic [VC_W-1:0]    res_vc
);

    port_e           next_port;
    logic [VC_W-1:0] next_vc;

    generate
        if (ALG == ALG_TABLE) begin : g_table
            logic unused_coords;
            assign unused_coords = ^{dest_x, dest_y, local_x, local_y};

            rcu_table #(
                .FLOW_W (FLOW_W),
                .VC_W   (VC_W)
            ) i_table (
                .clk     (clk),
                .rst     (rst),
                .wr_en   (tbl_wr_en),
                .wr_addr (tbl_wr_addr),
                .wr_port (tbl_wr_port),
                .wr_vc   (tbl_wr_vc),
                .rd_addr (flow_id),
                .rd_port (next_port),
                .rd_vc   (next_vc)
            );
        end else begin : g_dor
            logic unused_tbl;
            assign unused_tbl = ^{flow_id, tbl_wr_en, tbl_wr_addr, tbl_wr_port, tbl_wr_vc};

            rcu_dor #(
                .COORD_W (COORD_W),
                .Y_FIRST (ALG == ALG_YX)
            ) i_dor (
                .dest_x (dest_x),
                .dest_y (dest_y),
                .here_x (local_x),
                .here_y (local_y),
                .port   (next_port)
            );
            assign next_vc = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_port  <= PORT_LOCAL;
            res_vc    <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_port <= next_port;
                res_vc   <= next_vc;
            end
        end
    end

endmodule

// File: rtl/route_compute_chk.sv
module route_compute_chk #(
    parameter int COORD_W = 3,
    parameter int VC_W    = 1,
    parameter int ALG     = 0
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [COORD_W-1:0] dest_x,
    input logic [COORD_W-1:0] dest_y,
    input logic [COORD_W-1:0] local_x,
    input logic [COORD_W-1:0] local_y,
    input logic               res_valid,
    input logic [2:0]         res_port,
    input logic [VC_W-1:0]    res_vc
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!res_valid && res_port == 3'd0 && res_vc == '0));

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !res_valid);

    // R3
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(res_port) && $stable(res_vc)));

    // R4
    port_range_chk: assert property (@(posedge clk) disable iff (rst)
        res_port <= 3'd4);

    generate
        if (ALG == 0) begin : g_xy
            // R5
            xy_east_first_chk: assert property (@(posedge clk) disable iff (rst)
                (req_valid && dest_x > local_x) |=> res_port == 3'd1);
            // R5
            xy_north_chk: assert property (@(posedge clk) disable iff (rst)
                (req_valid && dest_x == local_x && dest_y > local_y) |=> res_port == 3'd3);
        end
        if (ALG == 1) begin : g_yx
            // R6
            yx_north_first_chk: assert property (@(posedge clk) disable iff (rst)
                (req_valid && dest_y > local_y) |=> res_port == 3'd3);
            // R6
            yx_west_chk: assert property (@(posedge clk) disable iff (rst)
                (req_valid && dest_y == local_y && dest_x < local_x) |=> res_port == 3'd2);
        end
        if (ALG != 2) begin : g_dor
            // R4
            here_is_local_chk: assert property (@(posedge clk) disable iff (rst)
                (req_valid && dest_x == local_x && dest_y == local_y) |=> res_port == 3'd0);
            // R7
            dor_vc_zero_chk: assert property (@(posedge clk) disable iff (rst)
                res_vc == '0);
        end
    endgenerate

endmodule

bind route_compute_unit route_compute_chk #(
    .COORD_W (COORD_W),
    .VC_W    (VC_W),
    .ALG     (ALG)
) i_route_compute_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .dest_x    (dest_x),
    .dest_y    (dest_y),
    .local_x   (local_x),
    .local_y   (local_y),
    .res_valid (res_valid),
    .res_port  (res_port),
    .res_vc    (res_vc)
);

// File: tb/test_route_compute_unit.sv
module test_route_compute_unit;

    localparam int CW = 3;
    localparam int FW = 4;
    localparam int VW = 1;
    localparam int DEPTH = 1 << FW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [CW-1:0] dest_x = '0, dest_y = '0, local_x = '0, local_y = '0;
    logic [FW-1:0] flow_id = '0, tbl_wr_addr = '0;
    logic          tbl_wr_en = 1'b0;
    logic [2:0]    tbl_wr_port = '0;
    logic [VW-1:0] tbl_wr_vc = '0;

    logic          xy_v, yx_v, tb_v;
    logic [2:0]    xy_p, yx_p, tb_p;
    logic [VW-1:0] xy_c, yx_c, tb_c;

    int checks = 0;
    int errors = 0;

    int         m_port [DEPTH];
    int         m_vc   [DEPTH];
    int         e_xy, e_yx, e_tp, e_tc;

    always #5 clk = ~clk;

    route_compute_unit #(.COORD_W(CW), .FLOW_W(FW), .NUM_VC(2), .ALG(0)) i_route_compute_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .dest_x(dest_x), .dest_y(dest_y),
        .flow_id(flow_id), .local_x(local_x), .local_y(local_y), .tbl_wr_en(tbl_wr_en),
        .tbl_wr_addr(tbl_wr_addr), .tbl_wr_port(tbl_wr_port), .tbl_wr_vc(tbl_wr_vc),
        .res_valid(xy_v), .res_port(xy_p), .res_vc(xy_c));

    route_compute_unit #(.COORD_W(CW), .FLOW_W(FW), .NUM_VC(2), .ALG(1)) i_route_compute_unit_yx (
        .clk(clk), .rst(rst), .req_valid(req_valid), .dest_x(dest_x), .dest_y(dest_y),
        .flow_id(flow_id), .local_x(local_x), .local_y(local_y), .tbl_wr_en(tbl_wr_en),
        .tbl_wr_addr(tbl_wr_addr), .tbl_wr_port(tbl_wr_port), .tbl_wr_vc(tbl_wr_vc),
        .res_valid(yx_v), .res_port(yx_p), .res_vc(yx_c));

    route_compute_unit #(.COORD_W(CW), .FLOW_W(FW), .NUM_VC(2), .ALG(2)) i_route_compute_unit_tbl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .dest_x(dest_x), .dest_y(dest_y),
        .flow_id(flow_id), .local_x(local_x), .local_y(local_y), .tbl_wr_en(tbl_wr_en),
        .tbl_wr_addr(tbl_wr_addr), .tbl_wr_port(tbl_wr_port), .tbl_wr_vc(tbl_wr_vc),
        .res_valid(tb_v), .res_port(tb_p), .res_vc(tb_c));

    function automatic int ref_xy(int dx, int dy, int lx, int ly);
        if (dx > lx) return 1;
        if (dx < lx) return 2;
        if (dy > ly) return 3;
        if (dy < ly) return 4;
        return 0;
    endfunction

    function automatic int ref_yx(int dx, int dy, int lx, int ly);
        if (dy > ly) return 3;
        if (dy < ly) return 4;
        if (dx > lx) return 1;
        if (dx < lx) return 2;
        return 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // One cycle: inputs set after a falling edge, results compared at the next one.
    task automatic cycle(input bit rv, input int dx, input int dy, input int lx, input int ly,
                         input int fid, input bit we, input int wa, input int wp, input int wv);
        req_valid   = rv;
        dest_x      = CW'(dx);
        dest_y      = CW'(dy);
        local_x     = CW'(lx);
        local_y     = CW'(ly);
        flow_id     = FW'(fid);
        tbl_wr_en   = we;
        tbl_wr_addr = FW'(wa);
        tbl_wr_port = 3'(wp);
        tbl_wr_vc   = VW'(wv);
        if (rv) begin
            e_xy = ref_xy(dx, dy, lx, ly);
            e_yx = ref_yx(dx, dy, lx, ly);
            e_tp = m_port[fid];
            e_tc = m_vc[fid];
        end
        @(negedge clk);
        if (we) begin
            m_port[wa] = (wp > 4) ? 0 : wp;
            m_vc[wa]   = wv;
        end
        chk("R2 xy valid", int'(xy_v), int'(rv));
        chk("R2 tbl valid", int'(tb_v), int'(rv));
        chk("R5 xy port", int'(xy_p), e_xy);
        chk("R6 yx port", int'(yx_p), e_yx);
        chk("R7 dor vc", int'(xy_c) + int'(yx_c), 0);
        chk("R8 table port", int'(tb_p), e_tp);
        chk("R8 table vc", int'(tb_c), e_tc);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) begin
            m_port[i] = 0;
            m_vc[i]   = 0;
        end
        e_xy = 0; e_yx = 0; e_tp = 0; e_tc = 0;
        repeat (3) @(negedge clk);
        // R1
        chk("R1 valid", int'(xy_v | yx_v | tb_v), 0);
        chk("R1 port", int'(xy_p | yx_p | tb_p), 0);
        chk("R1 vc", int'(xy_c | yx_c | tb_c), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", int'(tb_v), 0);

        // R11: untouched entry reads local / vc 0
        cycle(1, 7, 7, 0, 0, 5, 0, 0, 0, 0);
        chk("R11 reset entry", int'(tb_p) + int'(tb_c), 0);
        // R4: destination equals local node
        cycle(1, 3, 4, 3, 4, 0, 0, 0, 0, 0);
        chk("R4 local xy", int'(xy_p), 0);
        chk("R4 local yx", int'(yx_p), 0);
        // R5/R6: both coordinates differ
        cycle(1, 1, 6, 5, 2, 0, 0, 0, 0, 0);
        chk("R5 xy west first", int'(xy_p), 2);
        chk("R6 yx north first", int'(yx_p), 3);
        // R5: same column goes along Y
        cycle(1, 2, 0, 2, 5, 0, 0, 0, 0, 0);
        chk("R5 xy south", int'(xy_p), 4);
        // R3: idle cycle keeps previous result
        cycle(0, 7, 7, 0, 0, 3, 0, 0, 0, 0);
        chk("R3 hold xy", int'(xy_p), 4);
        // R9: write and read same entry in one cycle returns old data
        cycle(1, 0, 0, 0, 0, 9, 1, 9, 3, 1);
        chk("R9 same cycle old", int'(tb_p), 0);
        cycle(1, 0, 0, 0, 0, 9, 0, 0, 0, 0);
        chk("R9 next cycle new", int'(tb_p), 3);
        chk("R9 next cycle vc", int'(tb_c), 1);
        // R10: illegal code stored as local
        cycle(0, 0, 0, 0, 0, 0, 1, 9, 6, 1);
        cycle(1, 0, 0, 0, 0, 9, 0, 0, 0, 0);
        chk("R10 illegal code", int'(tb_p), 0);
        // R7/R8: flow id and coordinates ignored by the other scheme
        cycle(1, 6, 6, 1, 1, 2, 1, 2, 4, 1);
        cycle(1, 0, 0, 7, 7, 2, 0, 0, 0, 0);
        chk("R8 coords ignored", int'(tb_p), 4);
        chk("R7 flow ignored", int'(xy_p), 2);

        for (int n = 0; n < 400; n++) begin
            cycle(($urandom % 4) != 0,
                  int'($urandom % 8), int'($urandom % 8), int'($urandom % 8), int'($urandom % 8),
                  int'($urandom % DEPTH), ($urandom % 3) == 0, int'($urandom % DEPTH),
                  int'($urandom % 8), int'($urandom % 2));
        end
        finish_run();
    end

endmodule